// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between the internal clocks of a clock synthesizer and its output pins. A single input pin has two meanings: after reset it is an active-low power-good signal, and once it has been seen low it becomes an active-high power-down request. When power-down is recognised, every output is parked without a runt pulse. After all outputs are parked, the block asks for the oscillator and VCO to be switched off. When power-down is released, the outputs come back once the PLL reports lock.

All source clocks are modelled as slow waveforms that are synchronous to a fast sequencer clock `clk`. The pin is asynchronous and passes through a synchronizer. Power-down is recognised only after the synchronised pin is seen high at two consecutive rising edges of the CPU complement clock. Each output has its own enable register, and that register changes only during the low phase of the output's own source. A single-ended clock is gated low. A differential pair is parked in one of two ways, chosen by its drive-mode bit: true leg driven high with the complement leg tri-stated, or both legs tri-stated.

Top module: `clk_stop_sequencer`

## Requirements
- R1: After reset, `status` is 0 (power-good wait), every single-ended output is low, `oscOffReq` is low, every complement leg is tri-stated (`diffCOe`=0), and a pair whose `driveMode` bit is 0 drives its true leg high (`diffTOe`=1, `diffTOut`=1).
- R2: While the synchronised pin stays high in power-good wait, `status` stays 0. When the pin goes low, `status` becomes 4 (lock wait), and it becomes 1 (running) once `pllLock` is high.
- R3: While running, power-down is recognised only when the synchronised pin is high at two consecutive rising edges of `cpuClkC`. A shorter high pulse is ignored and `status` stays 1.
- R4: A single-ended output starts and stops only while its source clock is low. Every high pulse it emits therefore lasts exactly one full high phase of its source.
- R5: A differential pair parks and releases only while its complement source is low, so every low pulse on its true leg is a full source phase. Once power-down is recognised, all pairs are parked within four periods of the slowest pair.
- R6: A parked pair whose `driveMode` bit is 0 drives its true leg high and tri-states its complement leg.
- R7: Outside lock wait, a parked pair whose `driveMode` bit is 1 tri-states both legs.
- R8: While outputs are being parked, `status` is 2 (stopping). `oscOffReq` is high only in state 3 (powered down), and it rises only after every output is parked.
- R9: When the pin goes low in the powered-down state, `status` becomes 4, `oscOffReq` drops, and every true leg is driven high. No output is enabled until `pllLock` is high.
- R10: If the pin goes high again during lock wait, `status` returns to 3 and no output is enabled on the way.
- R11: After lock, all outputs resume toggling, and their first rising edges fall within one period of the slowest single-ended source of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrPin | input | 1 | Shared power-good / power-down pin, asynchronous |
| cpuClkC | input | 1 | CPU complement clock used to sample the pin |
| seClkIn | input | NUM_SE | Single-ended source clocks |
| diffTIn | input | NUM_DIFF | True legs of differential source clocks |
| diffCIn | input | NUM_DIFF | Complement legs of differential source clocks |
| driveMode | input | NUM_DIFF | Per-pair park mode: 0 true high, 1 both tri-stated |
| pllLock | input | 1 | PLL lock indication |
| seClkOut | output | NUM_SE | Gated single-ended clocks |
| diffTOut | output | NUM_DIFF | True leg data |
| diffTOe | output | NUM_DIFF | True leg output enable |
| diffCOut | output | NUM_DIFF | Complement leg data |
| diffCOe | output | NUM_DIFF | Complement leg output enable |
| oscOffReq | output | 1 | Request to switch the oscillator and VCO off |
| status | output | 3 | Sequencer state code: 0 power-good wait, 1 running, 2 stopping, 3 powered down, 4 lock wait |

## Verification
The edge-safety assertions assume that each source clock and `cpuClkC` change only between edges of `clk` and stay in each phase for at least one `clk` cycle. They also assume that every differential complement input is the exact inverse of its true input. The bench derives all sources from a cycle counter on the falling edge of `clk`, with half periods of three or more cycles, and drives each complement as the inverse of its true leg. The recognition and abort assertions assume that `pllLock` and the pin are held for many cycles. The bench changes these inputs only on the falling edge of `clk` and holds each level until the state it expects has been reached.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  typedef enum logic [2:0] {
    ST_PGWAIT   = 3'd0,
    ST_RUN      = 3'd1,
    ST_STOP     = 3'd2,
    ST_DOWN     = 3'd3,
    ST_LOCKWAIT = 3'd4
  } seqState_e;

  // strobes from control to the gating datapath
  typedef struct packed {
    logic wantOn;    // outputs should run
    logic forceTrue; // drive every true leg high while waiting for lock
  } gateCtl_t;

endpackage

// File: rtl/pd_sampler.sv
module pd_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int PD_SAMPLES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  input  logic cpuClkC,
  input  logic clrCnt,
  output logic pinLevel,
  output logic pdSeen
);
  localparam int CNT_W = $clog2(PD_SAMPLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   cpuCd;
  logic                   cpuRise;
  logic [CNT_W-1:0]       hiCnt;

  // reset value is high: the pin reads as "power not yet good"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinAsync};
  end

  assign pinLevel = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuCd <= 1'b0;
    else       cpuCd <= cpuClkC;
  end

  assign cpuRise = cpuClkC & ~cpuCd;

  // consecutive high samples taken on CPU complement rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
    end else if (clrCnt) begin
      hiCnt <= '0;
    end else if (cpuRise) begin
      if (!pinLevel)                           hiCnt <= '0;
      else if (hiCnt != CNT_W'(PD_SAMPLES))    hiCnt <= hiCnt + 1'b1;
    end
  end

  assign pdSeen = (hiCnt == CNT_W'(PD_SAMPLES));

  // R3: recognition only ever follows a high sample of the pin
  a_r3_seen_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdSeen) |-> $past(pinLevel));

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import clk_stop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinLevel,
  input  logic      pdSeen,
  input  logic      pllLock,
  input  logic      allParked,
  output seqState_e state,
  output gateCtl_t  ctl,
  output logic      clrCnt,
  output logic      oscOffReq
);
  seqState_e nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PGWAIT:   if (!pinLevel) nextState = ST_LOCKWAIT;
      ST_LOCKWAIT: begin
        if (pinLevel)     nextState = ST_DOWN;
        else if (pllLock) nextState = ST_RUN;
      end
      ST_RUN:      if (pdSeen)    nextState = ST_STOP;
      ST_STOP:     if (allParked) nextState = ST_DOWN;
      ST_DOWN:     if (!pinLevel) nextState = ST_LOCKWAIT;
      default:     nextState = ST_PGWAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PGWAIT;
    else       state <= nextState;
  end

  always_comb begin
    ctl.wantOn    = (state == ST_RUN);
    ctl.forceTrue = (state == ST_LOCKWAIT);
    clrCnt        = (state != ST_RUN);
    oscOffReq     = (state == ST_DOWN);
  end

  // R8: oscillator shut-off is only requested with every output parked
  a_r8_osc_after_park: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscOffReq) |-> allParked);

  // R3: stopping is entered only from running after a recognised request
  a_r3_stop_from_run: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && $past(state) != ST_STOP) |-> $past(pdSeen));

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import clk_stop_pkg::*;
#(
  parameter int NUM_SE   = 2,
  parameter int NUM_DIFF = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateCtl_t            ctl,
  input  logic [NUM_SE-1:0]   seIn,
  input  logic [NUM_DIFF-1:0] dfT,
  input  logic [NUM_DIFF-1:0] dfC,
  input  logic [NUM_DIFF-1:0] mode,
  output logic [NUM_SE-1:0]   seOut,
  output logic [NUM_DIFF-1:0] tOut,
  output logic [NUM_DIFF-1:0] tOe,
  output logic [NUM_DIFF-1:0] cOut,
  output logic [NUM_DIFF-1:0] cOe,
  output logic                allParked
);
  logic [NUM_SE-1:0]   seEn;
  logic [NUM_DIFF-1:0] dfEn;

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se
    // enable moves only in the low phase: no runt either way
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        seEn[i] <= 1'b0;
      else if (!seIn[i]) seEn[i] <= ctl.wantOn;
    end

    assign seOut[i] = seIn[i] & seEn[i];

    // R4: enable changes only while the source was low
    a_r4_se_edge_safe: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(seEn[i]) || $fell(seEn[i])) |-> !$past(seIn[i]));
  end

  for (genvar j = 0; j < NUM_DIFF; j++) begin : g_df
    // park/release while the complement leg is low (true leg high)
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        dfEn[j] <= 1'b0;
      else if (!dfC[j]) dfEn[j] <= ctl.wantOn;
    end

    always_comb begin
      if (dfEn[j]) begin
        tOut[j] = dfT[j];
        tOe[j]  = 1'b1;
        cOut[j] = dfC[j];
        cOe[j]  = 1'b1;
      end else begin
        tOut[j] = 1'b1;
        tOe[j]  = ~mode[j] | ctl.forceTrue;
        cOut[j] = 1'b0;
        cOe[j]  = 1'b0;
      end
    end

    // R5: pair enable changes only while the complement was low
    a_r5_diff_edge_safe: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(dfEn[j]) || $fell(dfEn[j])) |-> !$past(dfC[j]));
  end

  assign allParked = ~(|seEn) & ~(|dfEn);

endmodule

// File: rtl/clk_stop_sequencer.sv
module clk_stop_sequencer
  import clk_stop_pkg::*;
#(
  parameter int NUM_SE      = 2,
  parameter int NUM_DIFF    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PD_SAMPLES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrPin,
  input  logic                cpuClkC,
  input  logic [NUM_SE-1:0]   seClkIn,
  input  logic [NUM_DIFF-1:0] diffTIn,
  input  logic [NUM_DIFF-1:0] diffCIn,
  input  logic [NUM_DIFF-1:0] driveMode,
  input  logic                pllLock,
  output logic [NUM_SE-1:0]   seClkOut,
  output logic [NUM_DIFF-1:0] diffTOut,
  output logic [NUM_DIFF-1:0] diffTOe,
  output logic [NUM_DIFF-1:0] diffCOut,
  output logic [NUM_DIFF-1:0] diffCOe,
  output logic                oscOffReq,
  output logic [2:0]          status
);
  logic      pinLevel;
  logic      pdSeen;
  logic      clrCnt;
  logic      allParked;
  seqState_e state;
  gateCtl_t  ctl;

  pd_sampler #(
    .SYNC_STAGES (SYNC_STAGES),
    .PD_SAMPLES  (PD_SAMPLES)
  ) u_sampler (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync (pwrPin),
    .cpuClkC  (cpuClkC),
    .clrCnt   (clrCnt),
    .pinLevel (pinLevel),
    .pdSeen   (pdSeen)
  );

  gate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pinLevel  (pinLevel),
    .pdSeen    (pdSeen),
    .pllLock   (pllLock),
    .allParked (allParked),
    .state     (state),
    .ctl       (ctl),
    .clrCnt    (clrCnt),
    .oscOffReq (oscOffReq)
  );

  gate_datapath #(
    .NUM_SE   (NUM_SE),
    .NUM_DIFF (NUM_DIFF)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .seIn      (seClkIn),
    .dfT       (diffTIn),
    .dfC       (diffCIn),
    .mode      (driveMode),
    .seOut     (seClkOut),
    .tOut      (diffTOut),
    .tOe       (diffTOe),
    .cOut      (diffCOut),
    .cOe       (diffCOe),
    .allParked (allParked)
  );

  assign status = state;

  // R9: lock wait keeps everything off with every true leg driven high
  a_r9_lockwait_pins: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_LOCKWAIT) |-> (seClkOut == '0 && diffCOe == '0 &&
                                 (&diffTOe) && (&diffTOut)));

  // R10/R8: powered down means nothing toggles and no complement is driven
  a_r10_down_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_DOWN) |-> (seClkOut == '0 && diffCOe == '0));

endmodule

// File: tb/clk_stop_sequencer_bench.sv
module clk_stop_sequencer_bench;
  localparam int NSE = 2;
  localparam int ND  = 2;
  localparam int SE_H [NSE] = '{4, 6};
  localparam int DF_H [ND]  = '{3, 5};
  localparam int CPU_H = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrPin = 1'b1;
  logic cpuClkC = 1'b0;
  logic pllLock = 1'b0;
  logic [NSE-1:0] seClkIn = '0;
  logic [ND-1:0]  diffTIn = '0;
  logic [ND-1:0]  diffCIn = '1;
  logic [ND-1:0]  driveMode = 2'b10;
  logic [NSE-1:0] seClkOut;
  logic [ND-1:0]  diffTOut, diffTOe, diffCOut, diffCOe;
  logic           oscOffReq;
  logic [2:0]     status;

  int runCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  int n = 0;

  clk_stop_sequencer #(.NUM_SE(NSE), .NUM_DIFF(ND)) u_clk_stop_sequencer (
    .clk(clk), .rstN(rstN), .pwrPin(pwrPin), .cpuClkC(cpuClkC),
    .seClkIn(seClkIn), .diffTIn(diffTIn), .diffCIn(diffCIn),
    .driveMode(driveMode), .pllLock(pllLock), .seClkOut(seClkOut),
    .diffTOut(diffTOut), .diffTOe(diffTOe), .diffCOut(diffCOut),
    .diffCOe(diffCOe), .oscOffReq(oscOffReq), .status(status));

  always #2 clk = ~clk;

  always @(posedge clk) cyc++;

  // source waveforms, all changed on the falling edge of clk
  always @(negedge clk) begin
    n++;
    for (int i = 0; i < NSE; i++) seClkIn[i] = ((n / SE_H[i]) % 2) == 1;
    for (int j = 0; j < ND; j++) begin
      diffTIn[j] = ((n / DF_H[j]) % 2) == 1;
      diffCIn[j] = ~diffTIn[j];
    end
    cpuClkC = ((n / CPU_H) % 2) == 1;
  end

  task automatic check(input string req, input bit ok, input string act, input string exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // side monitors: pulse widths, oscillator request, resume timing
  int seRun [NSE];
  int dfRun [ND];
  int seRunt = 0, dfRunt = 0, oscBad = 0;
  int seRises [NSE];
  int dfRises [ND];
  int firstRise [NSE];
  logic [NSE-1:0] sePrev = '0;
  logic [ND-1:0]  tPrev = '1;
  logic [2:0]     stPrev = 3'd0;
  bit trackOn = 1'b0;
  int trackStart = 0;

  initial begin
    for (int i = 0; i < NSE; i++) begin seRun[i] = 0; seRises[i] = 0; firstRise[i] = -1; end
    for (int j = 0; j < ND; j++) begin dfRun[j] = 0; dfRises[j] = 0; end
  end

  always begin
    @(posedge clk); #1;
    if (rstN) begin
      for (int i = 0; i < NSE; i++) begin
        if (seClkOut[i]) seRun[i]++;
        else begin
          if (seRun[i] != 0 && seRun[i] != SE_H[i]) seRunt++;
          seRun[i] = 0;
        end
        if (seClkOut[i] && !sePrev[i]) begin
          seRises[i]++;
          if (trackOn && firstRise[i] < 0) firstRise[i] = cyc - trackStart;
        end
      end
      for (int j = 0; j < ND; j++) begin
        if (!diffTOut[j]) dfRun[j]++;
        else begin
          if (dfRun[j] != 0 && dfRun[j] != DF_H[j]) dfRunt++;
          dfRun[j] = 0;
        end
        if (diffTOut[j] && !tPrev[j]) dfRises[j]++;
      end
      // oscOffReq must only be high in state 3, and only after stopping/lock wait
      if (oscOffReq && status != 3'd3) oscBad++;
      if (status == 3'd3 && stPrev == 3'd1) oscBad++;
      sePrev = seClkOut;
      tPrev  = diffTOut;
      stPrev = status;
    end
  end

  // scoreboard
  typedef struct {
    string          req;
    logic [2:0]     st;
    logic           osc;
    bit             pins;
    logic [NSE-1:0] se;
    logic [ND-1:0]  oeT;
    logic [ND-1:0]  oeC;
    logic [ND-1:0]  outT;
  } exp_t;

  exp_t q[$];

  always begin
    @(posedge clk); #1;
    while (q.size() > 0) begin
      exp_t e;
      logic [31:0] a, x;
      e = q.pop_front();
      a = {status, oscOffReq, 24'd0};
      x = {e.st, e.osc, 24'd0};
      if (e.pins) begin
        a[23:0] = {16'd0, seClkOut, diffTOe, diffCOe, diffTOut & diffTOe};
        x[23:0] = {16'd0, e.se, e.oeT, e.oeC, e.outT & e.oeT};
      end
      check(e.req, a == x, $sformatf("%h", a), $sformatf("%h", x));
    end
  end

  task automatic expectNow(input string req, input logic [2:0] st, input logic osc,
                           input bit pins, input logic [NSE-1:0] se,
                           input logic [ND-1:0] oeT, input logic [ND-1:0] oeC,
                           input logic [ND-1:0] outT);
    exp_t e;
    e.req = req; e.st = st; e.osc = osc; e.pins = pins;
    e.se = se; e.oeT = oeT; e.oeC = oeC; e.outT = outT;
    @(negedge clk);
    q.push_back(e);
    @(posedge clk); #2;
  endtask

  task automatic waitState(input logic [2:0] s, input int lim, input string req, output int at);
    bit hit = 1'b0;
    for (int k = 0; k < lim && !hit; k++) begin
      @(posedge clk); #1;
      if (status == s) hit = 1'b1;
    end
    at = cyc;
    check(req, hit, $sformatf("status=%0d", status), $sformatf("status=%0d", s));
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    runCnt++; failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    int tA, tB, lo, hi;
    repeat (5) @(negedge clk);
    // R1 reset state, pair0 mode 0 drives true high, pair1 mode 1 tri-stated
    expectNow("R1", 3'd0, 1'b0, 1'b1, 2'b00, 2'b01, 2'b00, 2'b01);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    expectNow("R2 pin high holds wait", 3'd0, 1'b0, 1'b1, 2'b00, 2'b01, 2'b00, 2'b01);
    pwrPin = 1'b0;
    waitState(3'd4, 20, "R2 enter lock wait", tA);
    expectNow("R9 lock wait pins", 3'd4, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00, 2'b11);
    @(negedge clk); pllLock = 1'b1;
    waitState(3'd1, 20, "R2 run after lock", tA);
    repeat (200) @(negedge clk);
    for (int i = 0; i < NSE; i++)
      check("R11 se toggling", seRises[i] >= 5, $sformatf("%0d", seRises[i]), ">=5");
    for (int j = 0; j < ND; j++)
      check("R11 diff toggling", dfRises[j] >= 5, $sformatf("%0d", dfRises[j]), ">=5");

    // R3 short pulse spanning at most one CPU complement rising edge
    pwrPin = 1'b1;
    repeat (2) @(negedge clk);
    pwrPin = 1'b0;
    repeat (30) @(negedge clk);
    expectNow("R3 short pulse ignored", 3'd1, 1'b0, 1'b0, '0, '0, '0, '0);

    // full power-down
    pwrPin = 1'b1;
    waitState(3'd2, 40, "R8 stopping state", tA);
    waitState(3'd3, 60, "R8 powered down", tB);
    check("R5 park latency", (tB - tA) <= 4 * DF_H[1] * 2 + 2,
          $sformatf("%0d", tB - tA), $sformatf("<=%0d", 4 * DF_H[1] * 2 + 2));
    expectNow("R6 R7 parked pins", 3'd3, 1'b1, 1'b1, 2'b00, 2'b01, 2'b00, 2'b01);
    @(negedge clk); pllLock = 1'b0;

    // release, no lock yet
    repeat (10) @(negedge clk);
    pwrPin = 1'b0;
    waitState(3'd4, 20, "R9 enter lock wait", tA);
    repeat (20) @(negedge clk);
    expectNow("R9 held off without lock", 3'd4, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00, 2'b11);

    // R10 abort during lock wait
    pwrPin = 1'b1;
    waitState(3'd3, 20, "R10 back to down", tA);
    expectNow("R10 nothing enabled", 3'd3, 1'b1, 1'b1, 2'b00, 2'b01, 2'b00, 2'b01);

    // resume with lock
    pwrPin = 1'b0;
    waitState(3'd4, 20, "R9 lock wait again", tA);
    @(negedge clk);
    pllLock = 1'b1;
    trackStart = cyc;
    trackOn = 1'b1;
    waitState(3'd1, 20, "R11 run after lock", tA);
    repeat (100) @(negedge clk);
    lo = 1000; hi = -1;
    for (int i = 0; i < NSE; i++) begin
      if (firstRise[i] >= 0 && firstRise[i] < lo) lo = firstRise[i];
      if (firstRise[i] > hi) hi = firstRise[i];
    end
    check("R11 all restarted", lo != 1000 && firstRise[0] >= 0 && firstRise[1] >= 0,
          $sformatf("%0d/%0d", firstRise[0], firstRise[1]), "both >=0");
    check("R11 restart spread", (hi - lo) <= 2 * SE_H[1],
          $sformatf("%0d", hi - lo), $sformatf("<=%0d", 2 * SE_H[1]));

    check("R4 no runt on single-ended", seRunt == 0, $sformatf("%0d", seRunt), "0");
    check("R5 no runt on true legs", dfRunt == 0, $sformatf("%0d", dfRunt), "0");
    check("R8 osc request timing", oscBad == 0, $sformatf("%0d", oscBad), "0");
    finishRun();
  end

endmodule